// File: doc/BRIEF.md
# Free-Running 64-bit Cycle Counter with Torn-Read Status

This block keeps a 64-bit count of clock cycles. Software sees it through a narrow register port as two 32-bit words and a control word. The count cannot be captured in one access. So the block does not latch the upper word when the lower word is read. Instead it watches for a carry out of the lower word. A carry that lands after the lower word has been read means a lower/upper pair read in that window may be inconsistent. The block then reports the pair as torn.

The expected access pattern has three reads: the lower word, the upper word, then the control word. The top bit of the control word is set when the pair just read is a valid snapshot. It is clear when software must repeat the three reads. Bit 0 of the control word starts and stops counting, and the count is kept while stopped. Software may also load either word through the same port, for example to preset the count. The word widths, the counter width and the register addresses are parameters.

Top module: `cyc_snap_counter`

## Requirements
- R1: After reset the count is 0 and counting is off. A control read returns 32'h8000_0000.
- R2: Writing the control word with bit 0 = 1 turns counting on from the next clock. From then the count rises by one every cycle.
- R3: Writing the control word with bit 0 = 0 stops counting. The count keeps its value while stopped.
- R4: The control word is at address 0x103, the lower count word at 0x104 and the upper count word at 0x105. A control read shows the run state in bit 0 and the status in bit 31, and bits 30..1 read 0.
- R5: The two words form a single 64-bit count. When the lower word steps past all-ones it becomes 0 and the upper word rises by one in the same cycle.
- R6: A read of the lower word clears the torn indication. If no carry out of the lower word follows, the next control read returns bit 31 = 1.
- R7: A carry out of the lower word marks the snapshot torn. This includes a carry on the clock edge that ends the lower-word read. Every control read then returns bit 31 = 0 until the next lower-word read.
- R8: A write to 0x104 or 0x105 loads that word with the write data. The count does not advance in a cycle with such a load, and a load does not change the torn indication.
- R9: The read data is 0 when no read is requested and for unmapped addresses. Reads of the upper word or the control word, and writes to unmapped addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_rd | input | 1 | Read strobe; a lower-word read clears the torn indication |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, combinational |

## Verification
The bench moves the lower word to just below all-ones and lets it wrap between the lower and upper reads. A design that ignored that carry would report a torn pair as valid. The bench also sets up a carry on the very edge that ends the lower-word read. A design that sampled the carry one cycle late, or let the read's clear win over the carry, would pass a lower word of all-ones paired with an already incremented upper word. The bench checks that the status stays clear across repeated control reads and returns after a retry. A design that cleared the status on any read, or never cleared it, fails there. It also checks that a word load neither advances the count nor counts as a tear.

// File: rtl/cyc_snap_pkg.sv
package cyc_snap_pkg;
   // control word bit positions (software decodes these)
   localparam int unsigned RUN_BIT = 0;
   localparam int unsigned OK_BIT  = 31;
endpackage

// File: rtl/cyc_snap_word.sv
module cyc_snap_word #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [WORD_W-1:0] ld_val,
   input  logic              inc_in,
   output logic [WORD_W-1:0] val,
   output logic              carry_out
);
   initial begin
      if (WORD_W < 1) $error("cyc_snap_word: WORD_W must be positive");
   end

   // carry leaves this slice when it steps past all-ones
   assign carry_out = inc_in & (&val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val <= '0;
      end else if (ld) begin
         val <= ld_val;
      end else if (inc_in) begin
         val <= val + 1'b1;
      end
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> val == $past(ld_val)); // R8
endmodule

// File: rtl/cyc_snap_tear.sv
module cyc_snap_tear (
   input  logic clk,
   input  logic rst_n,
   input  logic lo_rd,
   input  logic wrap,
   output logic tear_q
);
   // a carry on the same edge as the lower read still counts as a tear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tear_q <= 1'b0;
      end else begin
         tear_q <= (tear_q & ~lo_rd) | wrap;
      end
   end

   AST_WRAP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> tear_q); // R7
   AST_LO_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rd && !wrap) |=> !tear_q); // R6
endmodule

// File: rtl/cyc_snap_decode.sv
module cyc_snap_decode
   import cyc_snap_pkg::*;
#(
   parameter int unsigned        ADDR_W = 12,
   parameter int unsigned        DATA_W = 32,
   parameter int unsigned        NWORD  = 2,
   parameter logic [ADDR_W-1:0]  CTRL_ADDR = 'h103,
   parameter logic [ADDR_W-1:0]  LO_ADDR   = 'h104
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic                          reg_wr,
   input  logic                          reg_rd,
   input  logic                          run_q,
   input  logic                          tear_q,
   input  logic [NWORD-1:0][DATA_W-1:0]  word_val,
   output logic                          ctrl_wr,
   output logic [NWORD-1:0]              word_ld,
   output logic                          lo_rd,
   output logic [DATA_W-1:0]             rdata
);
   logic              ctrl_hit;
   logic [NWORD-1:0]  word_hit;

   assign ctrl_hit = (reg_addr == CTRL_ADDR);

   for (genvar gi = 0; gi < NWORD; gi++) begin : g_hit
      localparam logic [ADDR_W-1:0] WORD_ADDR = LO_ADDR + ADDR_W'(gi);
      assign word_hit[gi] = (reg_addr == WORD_ADDR);
      assign word_ld[gi]  = reg_wr & word_hit[gi];
   end

   assign ctrl_wr = reg_wr & ctrl_hit;
   assign lo_rd   = reg_rd & word_hit[0];

   always_comb begin
      rdata = '0;
      if (reg_rd) begin
         if (ctrl_hit) begin
            rdata[RUN_BIT] = run_q;
            rdata[OK_BIT]  = ~tear_q;
         end
         for (int i = 0; i < NWORD; i++) begin
            if (word_hit[i]) rdata = word_val[i];
         end
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |-> rdata == '0); // R9
   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ctrl_wr, word_ld}) <= 1); // R4
endmodule

// File: rtl/cyc_snap_counter.sv
module cyc_snap_counter
   import cyc_snap_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 12,
   parameter int unsigned        DATA_W    = 32,
   parameter int unsigned        CNT_W     = 64,
   parameter logic [ADDR_W-1:0]  CTRL_ADDR = 'h103,
   parameter logic [ADDR_W-1:0]  LO_ADDR   = 'h104
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int unsigned NWORD = CNT_W / DATA_W;

   initial begin
      if (DATA_W <= OK_BIT)       $error("cyc_snap_counter: DATA_W too narrow for status bit");
      if (CNT_W % DATA_W != 0)    $error("cyc_snap_counter: CNT_W must be a multiple of DATA_W");
      if (NWORD < 2)              $error("cyc_snap_counter: counter needs at least two words");
   end

   logic                          run_q;
   logic                          tear_q;
   logic                          ctrl_wr;
   logic                          lo_rd;
   logic                          any_ld;
   logic [NWORD-1:0]              word_ld;
   logic [NWORD-1:0][DATA_W-1:0]  word_val;
   logic [NWORD:0]                inc_chain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (ctrl_wr) begin
         run_q <= reg_wdata[RUN_BIT];
      end
   end

   // a load in any word holds the whole count for that cycle
   assign any_ld       = |word_ld;
   assign inc_chain[0] = run_q & ~any_ld;

   for (genvar gi = 0; gi < NWORD; gi++) begin : g_word
      cyc_snap_word #(.WORD_W(DATA_W)) u_word (
         .clk       (clk),
         .rst_n     (rst_n),
         .ld        (word_ld[gi]),
         .ld_val    (reg_wdata),
         .inc_in    (inc_chain[gi]),
         .val       (word_val[gi]),
         .carry_out (inc_chain[gi+1])
      );
   end

   cyc_snap_tear u_tear (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_rd  (lo_rd),
      .wrap   (inc_chain[1]),
      .tear_q (tear_q)
   );

   cyc_snap_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NWORD     (NWORD),
      .CTRL_ADDR (CTRL_ADDR),
      .LO_ADDR   (LO_ADDR)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .run_q    (run_q),
      .tear_q   (tear_q),
      .word_val (word_val),
      .ctrl_wr  (ctrl_wr),
      .word_ld  (word_ld),
      .lo_rd    (lo_rd),
      .rdata    (reg_rdata)
   );

   AST_LOW_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !any_ld && !(&word_val[0])) |=>
         (word_val[0] == $past(word_val[0]) + 1'b1) && $stable(word_val[1])); // R2
   AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !any_ld && (&word_val[0])) |=>
         (word_val[0] == '0) && (word_val[1] == $past(word_val[1]) + 1'b1)); // R5
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !any_ld) |=> $stable(word_val)); // R3
   AST_LOAD_NO_TEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (any_ld && !lo_rd) |=> $stable(tear_q)); // R8
endmodule

// File: tb/cyc_snap_counter_bench.sv
`timescale 1ns/1ps
module cyc_snap_counter_bench;
   localparam logic [11:0] A_CTRL = 12'h103;
   localparam logic [11:0] A_LO   = 12'h104;
   localparam logic [11:0] A_HI   = 12'h105;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] last_rd;

   // behavioural reference state
   logic [63:0] m_cnt;
   logic        m_run;
   logic        m_tear;

   always #10 clk = ~clk;

   cyc_snap_counter u_cyc_snap_counter (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         m_cnt <= 64'd0; m_run <= 1'b0; m_tear <= 1'b0;
      end else begin
         logic ld_lo, ld_hi, step, wrap;
         logic [63:0] nxt;
         ld_lo = reg_wr && reg_addr == A_LO;
         ld_hi = reg_wr && reg_addr == A_HI;
         step  = m_run && !ld_lo && !ld_hi;
         wrap  = step && (m_cnt[31:0] == 32'hFFFF_FFFF);
         nxt   = m_cnt;
         if (ld_lo) nxt[31:0]  = reg_wdata;
         if (ld_hi) nxt[63:32] = reg_wdata;
         if (step)  nxt = nxt + 64'd1;
         m_cnt <= nxt;
         if (reg_wr && reg_addr == A_CTRL) m_run <= reg_wdata[0];
         m_tear <= ((reg_rd && reg_addr == A_LO) ? 1'b0 : m_tear) | wrap;
      end
   end

   function automatic logic [31:0] model_rdata();
      if (!reg_rd) return 32'd0;
      if (reg_addr == A_CTRL) return {~m_tear, 30'd0, m_run};
      if (reg_addr == A_LO)   return m_cnt[31:0];
      if (reg_addr == A_HI)   return m_cnt[63:32];
      return 32'd0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // kind: 0 idle, 1 read, 2 write; compared with the model every cycle
   task automatic do_op(input int kind, input logic [11:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_rd    = (kind == 1);
      reg_wr    = (kind == 2);
      #2;
      last_rd = reg_rdata;
      check(req, reg_rdata, model_rdata());
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) do_op(0, '0, '0, req);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      do_op(1, A_CTRL, 0, "R1"); check("R1 ctrl", last_rd, 32'h8000_0000);
      do_op(1, A_LO, 0, "R1");   check("R1 lo", last_rd, 32'd0);
      do_op(1, A_HI, 0, "R1");
      idle(3, "R9");
      // R2 enable and count
      do_op(2, A_CTRL, 32'd1, "R2");
      idle(5, "R2");
      do_op(1, A_LO, 0, "R2");   check("R2 count", last_rd, 32'd5);
      do_op(1, A_CTRL, 0, "R4"); check("R4 ctrl", last_rd, 32'h8000_0001);
      // R3 stop and hold
      do_op(2, A_CTRL, 32'd0, "R3");
      do_op(1, A_LO, 0, "R3");
      begin
         logic [31:0] held;
         held = last_rd;
         idle(4, "R3");
         do_op(1, A_LO, 0, "R3"); check("R3 hold", last_rd, held);
      end
      // R8 preload both words
      do_op(2, A_LO, 32'hFFFF_FFF0, "R8");
      do_op(2, A_HI, 32'd5, "R8");
      do_op(1, A_LO, 0, "R8");   check("R8 lo load", last_rd, 32'hFFFF_FFF0);
      do_op(1, A_HI, 0, "R8");   check("R8 hi load", last_rd, 32'd5);
      // R7 wrap between lower and upper read
      do_op(2, A_CTRL, 32'd1, "R7");
      do_op(1, A_LO, 0, "R7");
      idle(20, "R5");
      do_op(1, A_HI, 0, "R5");   check("R5 carry", last_rd, 32'd6);
      do_op(1, A_CTRL, 0, "R7"); check("R7 torn", last_rd & 32'h8000_0000, 32'd0);
      // R6 retry gives a clean snapshot
      do_op(1, A_LO, 0, "R6");
      do_op(1, A_HI, 0, "R6");
      do_op(1, A_CTRL, 0, "R6"); check("R6 clean", last_rd & 32'h8000_0000, 32'h8000_0000);
      // R7 carry on the edge that ends the lower read
      do_op(2, A_CTRL, 32'd0, "R7");
      do_op(2, A_LO, 32'hFFFF_FFFF, "R7");
      do_op(2, A_HI, 32'd0, "R7");
      do_op(2, A_CTRL, 32'd1, "R7");
      do_op(1, A_LO, 0, "R7");   check("R7 edge lo", last_rd, 32'hFFFF_FFFF);
      do_op(1, A_HI, 0, "R7");   check("R7 edge hi", last_rd, 32'd1);
      do_op(1, A_CTRL, 0, "R7"); check("R7 edge torn", last_rd & 32'h8000_0000, 32'd0);
      do_op(1, A_CTRL, 0, "R7"); check("R7 persists", last_rd & 32'h8000_0000, 32'd0);
      // R8 load while counting: no advance, no tear
      do_op(1, A_LO, 0, "R6");
      do_op(2, A_LO, 32'd100, "R8");
      do_op(1, A_LO, 0, "R8");   check("R8 no advance", last_rd, 32'd100);
      do_op(1, A_CTRL, 0, "R8"); check("R8 no tear", last_rd, 32'h8000_0001);
      // R9 unmapped accesses
      do_op(1, 12'h106, 0, "R9"); check("R9 unmapped", last_rd, 32'd0);
      do_op(1, 12'h000, 0, "R9");
      do_op(2, 12'h106, 32'hFFFF_FFFF, "R9");
      do_op(1, A_CTRL, 0, "R9");  check("R9 ctrl kept", last_rd, 32'h8000_0001);
      idle(3, "R9");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule